// File: doc/BRIEF.md
# Host Bridge BAR Window Decoder

This block holds the address-window configuration of a host bridge in a small bank of 64-bit registers. Two of the windows are memory-mapped I/O apertures. Each one is described by a base register, a mask register and an enable bit. The third window is a register aperture with a fixed length of 4 KiB. Software reaches the bank through a synchronous read/write port that carries a byte address and full 64-bit words. Bit 63 is the most significant bit of every word.

From the stored values the block derives each window's base and size. It compares a system address against every enabled window, reports which window claims the address, and gives the offset into that window. At reset the bases and masks are loaded from values computed from a chip index and a unit index, so that each bridge instance starts at its own place in the address map. If a window is reprogrammed while it is enabled, or if a write targets an index with no register behind it, the block raises a one-cycle error pulse.

Top module: `bar_window_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registers load the following values, each shifted left by 14 bits. MMIO0 base: 0x3d00000000000 + 0x4000000000·chip + 0x1000000000·unit. MMIO1 base: 0x3ff8000000000 + 0x0200000000·chip + 0x0080000000·unit. Register-window base: 0x3fffe40000000 + 0x400000·chip + 0x100000·unit. MMIO0 mask: 0x3fff000000000. MMIO1 mask: 0x3ffff80000000. Enable: zero.
- R2: The register index is `reg_addr >> 3`. Index 0 is the MMIO0 base, 1 is the MMIO0 mask, 2 is the MMIO1 base and 3 is the MMIO1 mask. A write to any of these four keeps bits 63:30 and stores zero in bits 29:0.
- R3: Index 4 is the register-window base. A write to it keeps bits 63:26 and stores zero in bits 25:0.
- R4: Index 5 is the enable register. A write to it keeps bits 63:59 and clears the rest. Bit 63 enables MMIO0, bit 62 enables MMIO1 and bit 61 enables the register window.
- R5: While `reg_rd` is high, `reg_rdata` shows the stored value of the addressed register in the same cycle. It is zero for an undefined index, and zero while `reg_rd` is low.
- R6: An MMIO window's base is its base register shifted right by 14. Its size is the inverse of its mask register shifted right by 14, plus one. The window claims address `a` when it is enabled and base ≤ a < base + size.
- R7: The register window's base is its base register shifted right by 14. Its size is always 0x1000 bytes.
- R8: `win_hit` has at most one bit set. Bit 0 is MMIO0, bit 1 is MMIO1 and bit 2 is the register window. Where windows overlap, MMIO0 wins over MMIO1, and MMIO1 wins over the register window. `win_ofs` is the address minus the winning window's base, or zero when there is no hit.
- R9: A write to a base or mask register always updates the register. If that register's own window is enabled, `reg_err` is high for one cycle after the write edge. If the window is disabled, no error is raised.
- R10: A write to an index above 5 changes no register, and `reg_err` is high for one cycle after the write edge.
- R11: Bits 2:0 of `reg_addr` are ignored. `reg_err` stays low in any cycle that follows a cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_idx | input | CHIP_W | Chip index used to compute the reset bases |
| unit_idx | input | UNIT_W | Unit index used to compute the reset bases |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid in the same cycle as `reg_rd` |
| reg_err | output | 1 | One-cycle pulse for an illegal write |
| sys_addr | input | 50 | System address to decode |
| win_hit | output | 3 | Priority-resolved window hit, one-hot or zero |
| win_ofs | output | 50 | Offset into the winning window |

## Verification
The bench probes both edges of every window. It checks the last byte inside each window and the first byte past it. A design with an off-by-one size or an inclusive upper bound would claim the first outside byte. For the register window, a design that took the size from a mask would miss its 4 KiB end. The bench stacks all three windows on one base and switches them on in different combinations. A wrong priority order then shows up as the wrong `win_hit` bit or the wrong offset. It writes all-ones patterns and checks that each register keeps only its legal bits. It also sends writes to enabled windows, to disabled windows and to undefined indices, so that an error pulse tied to the wrong window, or an undefined write that leaks into a register, is reported.

// File: rtl/bwd_pkg.sv
// Shared constants and reset-value helpers for the BAR window decoder.
// Assumes a 64-bit register word and a fixed 14-bit base/size shift.
package bwd_pkg;
    localparam int DW        = 64;
    localparam int SHIFT     = 14;
    localparam int SAW       = DW - SHIFT;   // system address width
    localparam int NWIN      = 3;            // MMIO0, MMIO1, register window
    localparam int RWIN_SIZE = 4096;

    // register indices (byte address >> 3)
    localparam int RI_B0  = 0;
    localparam int RI_M0  = 1;
    localparam int RI_B1  = 2;
    localparam int RI_M1  = 3;
    localparam int RI_RB  = 4;
    localparam int RI_EN  = 5;
    localparam int RI_MAX = 5;

    // enable bit positions, in priority order
    localparam int EN_W0 = 63;
    localparam int EN_W1 = 62;
    localparam int EN_RW = 61;

    localparam logic [DW-1:0] MMIO_KEEP = {{(DW-30){1'b1}}, {30{1'b0}}};
    localparam logic [DW-1:0] RWIN_KEEP = {{(DW-26){1'b1}}, {26{1'b0}}};
    localparam logic [DW-1:0] EN_KEEP   = {{5{1'b1}}, {(DW-5){1'b0}}};

    localparam logic [DW-1:0] RST_MASK0 = 64'h3fff000000000 << SHIFT;
    localparam logic [DW-1:0] RST_MASK1 = 64'h3ffff80000000 << SHIFT;

    // reset base of MMIO window 0 for a chip/unit pair
    function automatic logic [DW-1:0] rst_base0(input logic [DW-1:0] c, input logic [DW-1:0] u);
        return (64'h3d00000000000 + 64'h4000000000 * c + 64'h1000000000 * u) << SHIFT;
    endfunction

    // reset base of MMIO window 1 for a chip/unit pair
    function automatic logic [DW-1:0] rst_base1(input logic [DW-1:0] c, input logic [DW-1:0] u);
        return (64'h3ff8000000000 + 64'h0200000000 * c + 64'h0080000000 * u) << SHIFT;
    endfunction

    // reset base of the register window for a chip/unit pair
    function automatic logic [DW-1:0] rst_rbase(input logic [DW-1:0] c, input logic [DW-1:0] u);
        return (64'h3fffe40000000 + 64'h400000 * c + 64'h100000 * u) << SHIFT;
    endfunction
endpackage

// File: rtl/bwd_regfile.sv
// Register bank: stores bases, masks and enables, masks write data,
// serves same-cycle reads and flags illegal writes one cycle later.
// Assumes full 64-bit accesses; address bits 2:0 are ignored.
module bwd_regfile
    import bwd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CHIP_W = 3,
    parameter int UNIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHIP_W-1:0] chip_idx,
    input  logic [UNIT_W-1:0] unit_idx,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              err,
    output logic [SAW-1:0]    base_hi [NWIN],
    output logic [SAW-1:0]    mask_hi [NWIN],
    output logic [NWIN-1:0]   win_en
);
    localparam int IDX_W = ADDR_W - 3;

    logic [DW-1:0] b0_q, m0_q, b1_q, m1_q, rb_q, en_q;
    logic [IDX_W-1:0] idx;
    logic          is_b0, is_m0, is_b1, is_m1, is_rb, is_en, undef;
    logic          bad_wr;
    logic          err_q;

    // decode the register index from the byte address
    always_comb begin
        idx   = addr[ADDR_W-1:3];
        is_b0 = (idx == IDX_W'(RI_B0));
        is_m0 = (idx == IDX_W'(RI_M0));
        is_b1 = (idx == IDX_W'(RI_B1));
        is_m1 = (idx == IDX_W'(RI_M1));
        is_rb = (idx == IDX_W'(RI_RB));
        is_en = (idx == IDX_W'(RI_EN));
        undef = (idx > IDX_W'(RI_MAX));
    end

    // classify a write as illegal: undefined index or enabled window touched
    always_comb begin
        bad_wr = wr && (undef
                        || ((is_b0 || is_m0) && en_q[EN_W0])
                        || ((is_b1 || is_m1) && en_q[EN_W1])
                        || (is_rb && en_q[EN_RW]));
    end

    // register storage with per-register write masks and reset bases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b0_q <= rst_base0(DW'(chip_idx), DW'(unit_idx));
            b1_q <= rst_base1(DW'(chip_idx), DW'(unit_idx));
            rb_q <= rst_rbase(DW'(chip_idx), DW'(unit_idx));
            m0_q <= RST_MASK0;
            m1_q <= RST_MASK1;
            en_q <= '0;
        end else if (wr) begin
            if (is_b0) b0_q <= wdata & MMIO_KEEP;
            if (is_m0) m0_q <= wdata & MMIO_KEEP;
            if (is_b1) b1_q <= wdata & MMIO_KEEP;
            if (is_m1) m1_q <= wdata & MMIO_KEEP;
            if (is_rb) rb_q <= wdata & RWIN_KEEP;
            if (is_en) en_q <= wdata & EN_KEEP;
        end
    end

    // one-cycle error pulse after an illegal write
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bad_wr;
    end

    // same-cycle read multiplexer
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (1'b1)
                is_b0:   rdata = b0_q;
                is_m0:   rdata = m0_q;
                is_b1:   rdata = b1_q;
                is_m1:   rdata = m1_q;
                is_rb:   rdata = rb_q;
                is_en:   rdata = en_q;
                default: rdata = '0;
            endcase
        end
    end

    // present shifted window fields in priority order
    always_comb begin
        base_hi[0] = b0_q[DW-1:SHIFT];
        base_hi[1] = b1_q[DW-1:SHIFT];
        base_hi[2] = rb_q[DW-1:SHIFT];
        mask_hi[0] = m0_q[DW-1:SHIFT];
        mask_hi[1] = m1_q[DW-1:SHIFT];
        mask_hi[2] = '0;
        win_en     = {en_q[EN_RW], en_q[EN_W1], en_q[EN_W0]};
    end

    assign err = err_q;
endmodule

// File: rtl/bwd_window.sv
// One address window: derives size from a mask (or a fixed length),
// and tests an address against [base, base+size).
// Assumes base and mask are already shifted right by SHIFT.
module bwd_window #(
    parameter int  AW          = 50,
    parameter bit  FIXED       = 1'b0,
    parameter int  FIXED_BYTES = 4096
) (
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] ofs
);
    logic [AW:0] size;
    logic [AW:0] limit;

    generate
        if (FIXED) begin : g_fixed
            logic unused_mask;
            // fixed-length window ignores its mask
            assign unused_mask = ^mask;
            assign size        = (AW+1)'(FIXED_BYTES);
        end else begin : g_masked
            // size from the inverted mask plus one
            assign size = {1'b0, ~mask} + (AW+1)'(1);
        end
    endgenerate

    // range compare with one extra bit so the end never wraps
    always_comb begin
        limit = {1'b0, base} + size;
        hit   = en && (addr >= base) && ({1'b0, addr} < limit);
        ofs   = addr - base;
    end
endmodule

// File: rtl/bwd_hit_arb.sv
// Fixed-priority selector: the lowest-numbered hitting window wins;
// outputs a one-hot-or-zero vector and the winner's offset.
module bwd_hit_arb #(
    parameter int N = 3,
    parameter int W = 50
) (
    input  logic [N-1:0] hit_raw,
    input  logic [W-1:0] ofs_raw [N],
    output logic [N-1:0] hit_sel,
    output logic [W-1:0] ofs_sel
);
    // scan from lowest priority up so the highest priority overwrites
    always_comb begin
        hit_sel = '0;
        ofs_sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_raw[i]) begin
                hit_sel    = '0;
                hit_sel[i] = 1'b1;
                ofs_sel    = ofs_raw[i];
            end
        end
    end
endmodule

// File: rtl/bar_window_decoder.sv
// Top: register bank plus three window comparators and a priority pick.
// Window 2 is the fixed 4 KiB register window; the others use masks.
module bar_window_decoder
    import bwd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CHIP_W = 3,
    parameter int UNIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHIP_W-1:0] chip_idx,
    input  logic [UNIT_W-1:0] unit_idx,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              reg_err,
    input  logic [49:0]       sys_addr,
    output logic [2:0]        win_hit,
    output logic [49:0]       win_ofs
);
    logic [SAW-1:0]  base_hi [NWIN];
    logic [SAW-1:0]  mask_hi [NWIN];
    logic [NWIN-1:0] win_en;
    logic [NWIN-1:0] hit_raw;
    logic [SAW-1:0]  ofs_raw [NWIN];

    bwd_regfile #(
        .ADDR_W (ADDR_W),
        .CHIP_W (CHIP_W),
        .UNIT_W (UNIT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_idx (chip_idx),
        .unit_idx (unit_idx),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .err      (reg_err),
        .base_hi  (base_hi),
        .mask_hi  (mask_hi),
        .win_en   (win_en)
    );

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_win
            bwd_window #(
                .AW          (SAW),
                .FIXED       (g == NWIN - 1),
                .FIXED_BYTES (RWIN_SIZE)
            ) u_win (
                .en   (win_en[g]),
                .base (base_hi[g]),
                .mask (mask_hi[g]),
                .addr (sys_addr),
                .hit  (hit_raw[g]),
                .ofs  (ofs_raw[g])
            );
        end
    endgenerate

    bwd_hit_arb #(
        .N (NWIN),
        .W (SAW)
    ) u_arb (
        .hit_raw (hit_raw),
        .ofs_raw (ofs_raw),
        .hit_sel (win_hit),
        .ofs_sel (win_ofs)
    );
endmodule

// File: rtl/bar_window_decoder_chk.sv
// Port-level properties of the BAR window decoder, bound to the top.
module bar_window_decoder_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [63:0]       reg_rdata,
    input logic              reg_err,
    input logic [2:0]        win_hit,
    input logic [49:0]       win_ofs
);
    logic [ADDR_W-4:0] cidx;
    assign cidx = reg_addr[ADDR_W-1:3];

    a_r2_mmio_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && cidx <= 3) |-> (reg_rdata[29:0] == '0))
        else $error("R2 low bits set on MMIO register read");

    a_r3_rwin_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && cidx == 4) |-> (reg_rdata[25:0] == '0))
        else $error("R3 low bits set on register-window base read");

    a_r4_en_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && cidx == 5) |-> (reg_rdata[58:0] == '0))
        else $error("R4 enable register holds bits below 59");

    a_r5_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd || cidx > 5) |-> (reg_rdata == '0))
        else $error("R5 read data without a defined read");

    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_hit))
        else $error("R8 more than one window hit");

    a_r8_nohit_ofs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit == 3'b000) |-> (win_ofs == '0))
        else $error("R8 offset nonzero without a hit");

    a_r7_rwin_ofs_small: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit[2] |-> (win_ofs < 50'h1000))
        else $error("R7 register-window offset beyond 4 KiB");

    a_r10_undef_err: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && cidx > 5) |=> reg_err)
        else $error("R10 undefined write without error");

    a_r11_quiet_err: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> !reg_err)
        else $error("R11 error pulse without a write");
endmodule

bind bar_window_decoder bar_window_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_bar_window_decoder.sv
`timescale 1ns/1ps
module sim_bar_window_decoder;
    localparam int ADDR_W = 8;
    localparam int CHIP_W = 3;
    localparam int UNIT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CHIP_W-1:0] chip_idx = 3'd2;
    logic [UNIT_W-1:0] unit_idx = 2'd1;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;
    logic              reg_err;
    logic [49:0]       sys_addr = '0;
    logic [2:0]        win_hit;
    logic [49:0]       win_ofs;

    always #2 clk = ~clk;   // 250 MHz

    bar_window_decoder #(.ADDR_W(ADDR_W), .CHIP_W(CHIP_W), .UNIT_W(UNIT_W)) u0 (.*);

    typedef struct {
        int          kind;    // 0 read data, 1 error pulse, 2 hit/offset
        logic [63:0] data;
        logic [2:0]  hit;
        logic [49:0] ofs;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // expected values from the requirements, chip 2 unit 1
    localparam logic [63:0] MM0 = 64'h3d00000000000 + 64'h4000000000 * 2 + 64'h1000000000;
    localparam logic [63:0] MM1 = 64'h3ff8000000000 + 64'h0200000000 * 2 + 64'h0080000000;
    localparam logic [63:0] RB  = 64'h3fffe40000000 + 64'h400000 * 2 + 64'h100000;
    localparam logic [63:0] V   = 64'h0000100000000000;
    localparam logic [49:0] VB  = 50'(V >> 14);
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    // monitor: pops one expectation per cycle and compares away from the edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            case (it.kind)
                0: if (reg_rdata !== it.data) begin
                       bad++;
                       $display("FAIL %s: rdata=%h expected=%h", it.tag, reg_rdata, it.data);
                   end
                1: if (reg_err !== it.data[0]) begin
                       bad++;
                       $display("FAIL %s: err=%b expected=%b", it.tag, reg_err, it.data[0]);
                   end
                default: if (win_hit !== it.hit || win_ofs !== it.ofs) begin
                       bad++;
                       $display("FAIL %s: hit=%b ofs=%h expected hit=%b ofs=%h",
                                it.tag, win_hit, win_ofs, it.hit, it.ofs);
                   end
            endcase
        end
    end

    task automatic push(input int k, input logic [63:0] d, input logic [2:0] h,
                        input logic [49:0] o, input string tag);
        item_t it;
        it.kind = k; it.data = d; it.hit = h; it.ofs = o; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [63:0] exp, input string tag);
        reg_addr = a;
        reg_rd   = 1'b1;
        push(0, exp, 3'b0, '0, tag);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic idle_chk(input logic [ADDR_W-1:0] a, input string tag);
        reg_addr = a;
        reg_rd   = 1'b0;
        push(0, 64'h0, 3'b0, '0, tag);
        @(posedge clk); #1;
    endtask

    task automatic wr_chk(input logic [ADDR_W-1:0] a, input logic [63:0] d,
                          input bit exp_err, input string tag);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        push(1, {63'b0, exp_err}, 3'b0, '0, tag);
        @(posedge clk); #1;
    endtask

    task automatic hit_chk(input logic [49:0] a, input logic [2:0] h,
                           input logic [49:0] o, input string tag);
        sys_addr = a;
        push(2, 64'h0, h, o, tag);
        @(posedge clk); #1;
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish expected=finished");
            finish_run();
        end
    end

    // driver: stimulus sequence
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd_chk(8'h00, MM0 << 14, "R1 mmio0 base");
        rd_chk(8'h08, 64'h3fff000000000 << 14, "R1 mmio0 mask");
        rd_chk(8'h10, MM1 << 14, "R1 mmio1 base");
        rd_chk(8'h18, 64'h3ffff80000000 << 14, "R1 mmio1 mask");
        rd_chk(8'h20, RB << 14, "R1 regwin base");
        rd_chk(8'h28, 64'h0, "R1 enable");
        // R5 idle and undefined reads
        idle_chk(8'h00, "R5 no strobe");
        rd_chk(8'h30, 64'h0, "R5 undefined index");
        // R8 no hit while all disabled
        hit_chk(MM0[49:0] + 50'd5, 3'b000, '0, "R8 disabled no hit");

        // R4 enable masking
        wr_chk(8'h28, ONES, 1'b0, "R9 enable write no error");
        rd_chk(8'h28, 64'hF800000000000000, "R4 enable keeps 63:59");
        // R6 reset windows
        hit_chk(MM0[49:0] + 50'd5, 3'b001, 50'd5, "R6 mmio0 inside");
        hit_chk(MM0[49:0] + 50'h0FFFFFFFFF, 3'b001, 50'h0FFFFFFFFF, "R6 mmio0 last byte");
        hit_chk(MM0[49:0] + 50'h1000000000, 3'b000, '0, "R6 mmio0 end excluded");
        hit_chk(MM0[49:0] - 50'd1, 3'b000, '0, "R6 below mmio0");
        hit_chk(MM1[49:0] + 50'h10, 3'b010, 50'h10, "R6 mmio1 inside");
        hit_chk(MM1[49:0] + 50'h80000000, 3'b000, '0, "R6 mmio1 end excluded");
        hit_chk(RB[49:0] + 50'hFFF, 3'b100, 50'hFFF, "R7 regwin last byte");
        hit_chk(RB[49:0] + 50'h1000, 3'b000, '0, "R7 regwin end excluded");

        // R9 and R2 writes to enabled windows
        wr_chk(8'h00, ONES, 1'b1, "R9 mmio0 base while enabled");
        rd_chk(8'h00, 64'hFFFFFFFFC0000000, "R2 mmio0 base masked");
        idle_chk(8'h00, "R11 quiet cycle");
        wr_chk(8'h18, 64'h123456789ABCDEF0, 1'b1, "R9 mmio1 mask while enabled");
        rd_chk(8'h18, 64'h1234567880000000, "R2 mmio1 mask masked");

        // R10 undefined write
        wr_chk(8'h30, ONES, 1'b1, "R10 undefined write error");
        rd_chk(8'h28, 64'hF800000000000000, "R10 enable unchanged");
        rd_chk(8'h30, 64'h0, "R10 undefined still reads zero");

        // R11 low address bits ignored
        wr_chk(8'h2D, 64'h0, 1'b0, "R11 enable via unaligned address");
        rd_chk(8'h2F, 64'h0, "R11 enable cleared");

        // program overlapping windows while disabled
        wr_chk(8'h00, V, 1'b0, "R9 mmio0 base while disabled");
        wr_chk(8'h08, ONES, 1'b0, "R9 mmio0 mask while disabled");
        wr_chk(8'h10, V, 1'b0, "R9 mmio1 base while disabled");
        wr_chk(8'h18, ONES, 1'b0, "R9 mmio1 mask while disabled");
        wr_chk(8'h20, ONES, 1'b0, "R9 regwin base while disabled");
        rd_chk(8'h20, 64'hFFFFFFFFFC000000, "R3 regwin base masked");
        wr_chk(8'h20, V, 1'b0, "R9 regwin base while disabled");

        // R8 priority among overlapping windows
        wr_chk(8'h28, 64'hC000000000000000, 1'b0, "R4 enable mmio0 and mmio1");
        hit_chk(VB + 50'd3, 3'b001, 50'd3, "R8 mmio0 beats mmio1");
        hit_chk(VB + 50'hFFFF, 3'b001, 50'hFFFF, "R6 custom mask last byte");
        hit_chk(VB + 50'h10000, 3'b000, '0, "R6 custom mask end excluded");
        wr_chk(8'h28, 64'h4000000000000000, 1'b0, "R4 enable mmio1 only");
        hit_chk(VB + 50'd3, 3'b010, 50'd3, "R4 bit 62 selects mmio1");
        wr_chk(8'h28, 64'h2000000000000000, 1'b0, "R4 enable regwin only");
        hit_chk(VB + 50'd3, 3'b100, 50'd3, "R4 bit 61 selects regwin");
        hit_chk(VB + 50'h1000, 3'b000, '0, "R7 regwin ignores mask size");
        wr_chk(8'h28, 64'h6000000000000000, 1'b0, "R4 enable mmio1 and regwin");
        hit_chk(VB + 50'd3, 3'b010, 50'd3, "R8 mmio1 beats regwin");
        hit_chk(VB + 50'h2000, 3'b010, 50'h2000, "R8 only mmio1 past regwin");
        wr_chk(8'h20, V, 1'b1, "R9 regwin base while enabled");
        wr_chk(8'h08, ONES, 1'b0, "R9 mmio0 mask with mmio0 disabled");

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            finish_run();
        end
    end
endmodule